// File: doc/BRIEF.md
# Bridge I/O Window Decoder

This block decides whether a 16-bit I/O transaction address falls inside the I/O window of a downstream bridge port. Two 8-bit configuration registers hold the window: one for its bottom and one for its top. The upper nibble of each register carries address bits 15:12. In the fine mode, two more bits carry address bits 11:10, so the window can be set with a 1 KB step instead of a 4 KB step.

Software programs the registers through a simple write port. This port takes a one-bit register select, a data byte and a write strobe. Both registers can always be read back on dedicated read ports.

Three control inputs shape the behaviour:
- A granularity input selects the 4 KB or the 1 KB window step.
- A lock input freezes the fine bits.
- An I/O-space enable input gates the decision.

For each address marked valid, the block drives a registered forward flag on the following cycle.

Top module: `io_window_decoder`

## Requirements
- R1: After reset the bottom register reads 0xF0, the top register reads 0x00 and `fwd` is 0. With these values no address is forwarded.
- R2: A write with `cfg_wr_sel`=0 loads `cfg_wr_data[7:4]` into bits 7:4 of the bottom register. A write with `cfg_wr_sel`=1 loads the same bits into bits 7:4 of the top register. Both writes take effect for any state of `fine_gran_en` and `wr_lock`, and the new value is visible on the read ports on the cycle after the write edge.
- R3: Bits 1:0 of both read ports always read 0, whatever was written.
- R4: While `fine_gran_en`=0, bits 3:2 of both read ports read 0, and a write does not change the stored fine bits. The stored value shows again once the fine mode is turned on.
- R5: While `fine_gran_en`=1 and `wr_lock`=0, a write loads `cfg_wr_data[3:2]` into bits 3:2 of the selected register, and the value reads back there.
- R6: While `wr_lock`=1, writes leave bits 3:2 of both registers unchanged, even with `fine_gran_en`=1.
- R7: With `fine_gran_en`=0, an address is in the window when bottom[7:4] <= `addr[15:12]` <= top[7:4]. The window therefore runs from a 4 KB boundary up to an address whose bits 11:0 are all ones.
- R8: With `fine_gran_en`=1, an address is in the window when {bottom[7:4],bottom[3:2]} <= `addr[15:10]` <= {top[7:4],top[3:2]}. The window then starts on a 1 KB boundary and ends at an address whose bits 9:0 are all ones.
- R9: When the top value is below the bottom value, no address is forwarded.
- R10: `fwd` is registered. It is 1 on the cycle after an edge where `addr_valid`=1 and the address was in the window, and it is 0 after any edge where `addr_valid`=0.
- R11: While `io_space_en`=0, `fwd` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wr_en | input | 1 | Register write strobe |
| cfg_wr_sel | input | 1 | Register select: 0 bottom, 1 top |
| cfg_wr_data | input | 8 | Write data byte |
| fine_gran_en | input | 1 | Selects the 1 KB window step |
| wr_lock | input | 1 | Blocks writes to the fine bits 3:2 |
| io_space_en | input | 1 | Allows any forwarding |
| addr_valid | input | 1 | Address qualifier |
| addr | input | 16 | I/O transaction address |
| cfg_rd_base | output | 8 | Bottom register read value |
| cfg_rd_limit | output | 8 | Top register read value |
| fwd | output | 1 | Registered forward decision |

## Verification
The hardest situation to reach from the ports is a write to the fine bits that is dropped, because while the block sits in the coarse mode those bits read as zero anyway.

The bench reaches it in three steps:
1. It writes nonzero fine bits while in the coarse mode.
2. It turns on the fine mode.
3. It reads the register back, which must still show the old stored fine value.

For the lock, the bench writes while the lock is held in the fine mode and then reads the register, which must show the earlier fine value. Window edges are probed one address on each side of both boundaries, in both modes.

// File: rtl/io_win_pkg.sv
package io_win_pkg;
    localparam int REG_W    = 8;
    localparam int HI_W     = 4;
    localparam int FINE_W   = 2;
    localparam int CAP_W    = REG_W - HI_W - FINE_W;
    localparam int FINE_LSB = CAP_W;
    localparam int HI_LSB   = CAP_W + FINE_W;
    localparam int CMP_W    = HI_W + FINE_W;

    localparam logic SEL_BASE  = 1'b0;
    localparam logic SEL_LIMIT = 1'b1;

    typedef struct packed {
        logic [HI_W-1:0]   hi;
        logic [FINE_W-1:0] fine;
    } win_field_t;

    typedef struct packed {
        win_field_t bot;
        win_field_t top;
    } win_regs_t;

    localparam win_regs_t WIN_RESET = '{
        bot: '{hi: '1, fine: '0},
        top: '{hi: '0, fine: '0}
    };
endpackage

// File: rtl/iow_cfg_regs.sv
module iow_cfg_regs
    import io_win_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic             wr_sel,
    input  logic [REG_W-1:0] wr_data,
    input  logic             fine_en,
    input  logic             lock,
    output win_field_t       bot_q,
    output win_field_t       top_q,
    output logic [REG_W-1:0] rd_bot,
    output logic [REG_W-1:0] rd_top
);
    win_regs_t st_d, st_q;
    logic      fine_wr_ok;
    logic      unused_cap_bits;

    assign fine_wr_ok      = fine_en & ~lock;
    assign unused_cap_bits = ^wr_data[CAP_W-1:0];

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            if (wr_sel == SEL_BASE) begin
                st_d.bot.hi = wr_data[HI_LSB +: HI_W];
                if (fine_wr_ok) begin
                    st_d.bot.fine = wr_data[FINE_LSB +: FINE_W];
                end
            end else begin
                st_d.top.hi = wr_data[HI_LSB +: HI_W];
                if (fine_wr_ok) begin
                    st_d.top.fine = wr_data[FINE_LSB +: FINE_W];
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= WIN_RESET;
        end else begin
            st_q <= st_d;
        end
    end

    assign bot_q  = st_q.bot;
    assign top_q  = st_q.top;
    assign rd_bot = {st_q.bot.hi, fine_en ? st_q.bot.fine : {FINE_W{1'b0}}, {CAP_W{1'b0}}};
    assign rd_top = {st_q.top.hi, fine_en ? st_q.top.fine : {FINE_W{1'b0}}, {CAP_W{1'b0}}};
endmodule

// File: rtl/iow_range_cmp.sv
module iow_range_cmp
    import io_win_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  win_field_t        bot,
    input  win_field_t        top,
    input  logic              fine_en,
    input  logic [ADDR_W-1:0] addr,
    output logic              hit
);
    localparam int ALSB = ADDR_W - CMP_W;

    logic [CMP_W-1:0] lo_bound, hi_bound, a_key;
    logic             unused_low_addr;

    assign unused_low_addr = ^addr[ALSB-1:0];
    assign a_key           = addr[ADDR_W-1:ALSB];

    always_comb begin
        if (fine_en) begin
            lo_bound = {bot.hi, bot.fine};
            hi_bound = {top.hi, top.fine};
        end else begin
            lo_bound = {bot.hi, {FINE_W{1'b0}}};
            hi_bound = {top.hi, {FINE_W{1'b1}}};
        end
        hit = (a_key >= lo_bound) && (a_key <= hi_bound);
    end
endmodule

// File: rtl/iow_fwd_stage.sv
module iow_fwd_stage (
    input  logic clk,
    input  logic rst_n,
    input  logic valid,
    input  logic space_en,
    input  logic hit,
    output logic fwd
);
    logic fwd_d, fwd_q;

    always_comb begin
        fwd_d = valid & space_en & hit;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fwd_q <= 1'b0;
        end else begin
            fwd_q <= fwd_d;
        end
    end

    assign fwd = fwd_q;
endmodule

// File: rtl/io_window_decoder.sv
module io_window_decoder
    import io_win_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr_en,
    input  logic              cfg_wr_sel,
    input  logic [7:0]        cfg_wr_data,
    input  logic              fine_gran_en,
    input  logic              wr_lock,
    input  logic              io_space_en,
    input  logic              addr_valid,
    input  logic [ADDR_W-1:0] addr,
    output logic [7:0]        cfg_rd_base,
    output logic [7:0]        cfg_rd_limit,
    output logic              fwd
);
    win_field_t bot_q, top_q;
    logic       hit;

    iow_cfg_regs u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (cfg_wr_en),
        .wr_sel  (cfg_wr_sel),
        .wr_data (cfg_wr_data),
        .fine_en (fine_gran_en),
        .lock    (wr_lock),
        .bot_q   (bot_q),
        .top_q   (top_q),
        .rd_bot  (cfg_rd_base),
        .rd_top  (cfg_rd_limit)
    );

    iow_range_cmp #(.ADDR_W(ADDR_W)) u_cmp (
        .bot     (bot_q),
        .top     (top_q),
        .fine_en (fine_gran_en),
        .addr    (addr),
        .hit     (hit)
    );

    iow_fwd_stage u_fwd (
        .clk      (clk),
        .rst_n    (rst_n),
        .valid    (addr_valid),
        .space_en (io_space_en),
        .hit      (hit),
        .fwd      (fwd)
    );
endmodule

// File: rtl/io_window_decoder_chk.sv
module io_window_decoder_chk #(
    parameter int ADDR_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cfg_wr_en,
    input logic              cfg_wr_sel,
    input logic [7:0]        cfg_wr_data,
    input logic              fine_gran_en,
    input logic              wr_lock,
    input logic              io_space_en,
    input logic              addr_valid,
    input logic [ADDR_W-1:0] addr,
    input logic [7:0]        cfg_rd_base,
    input logic [7:0]        cfg_rd_limit,
    input logic              fwd
);
    AST_WR_BASE_HI: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr_en && !cfg_wr_sel) |=> cfg_rd_base[7:4] == $past(cfg_wr_data[7:4])); // R2
    AST_WR_LIMIT_HI: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr_en && cfg_wr_sel) |=> cfg_rd_limit[7:4] == $past(cfg_wr_data[7:4])); // R2
    AST_CAP_BITS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_rd_base[1:0] == 2'b00 && cfg_rd_limit[1:0] == 2'b00); // R3
    AST_COARSE_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !fine_gran_en |-> (cfg_rd_base[3:2] == 2'b00 && cfg_rd_limit[3:2] == 2'b00)); // R4
    AST_FINE_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr_en && !cfg_wr_sel && fine_gran_en && !wr_lock) |=>
        (!fine_gran_en || cfg_rd_base[3:2] == $past(cfg_wr_data[3:2]))); // R5
    AST_LOCK_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (fine_gran_en && wr_lock) |=>
        (!fine_gran_en || (cfg_rd_base[3:2] == $past(cfg_rd_base[3:2]) &&
                           cfg_rd_limit[3:2] == $past(cfg_rd_limit[3:2])))); // R6
    AST_FWD_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        fwd |-> ($past(addr[ADDR_W-1 -: 4]) >= $past(cfg_rd_base[7:4]) &&
                 $past(addr[ADDR_W-1 -: 4]) <= $past(cfg_rd_limit[7:4]))); // R7
    AST_NO_FWD_INVERTED: assert property (@(posedge clk) disable iff (!rst_n)
        fwd |-> $past(cfg_rd_limit[7:4] >= cfg_rd_base[7:4])); // R9
    AST_FWD_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        fwd |-> $past(addr_valid)); // R10
    AST_FWD_NEEDS_SPACE: assert property (@(posedge clk) disable iff (!rst_n)
        fwd |-> $past(io_space_en)); // R11
endmodule

bind io_window_decoder io_window_decoder_chk #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/tb_io_window_decoder.sv
module tb_io_window_decoder;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr_en = 1'b0;
    logic        cfg_wr_sel = 1'b0;
    logic [7:0]  cfg_wr_data = 8'h00;
    logic        fine_gran_en = 1'b0;
    logic        wr_lock = 1'b0;
    logic        io_space_en = 1'b0;
    logic        addr_valid = 1'b0;
    logic [15:0] addr = 16'h0000;
    logic [7:0]  cfg_rd_base, cfg_rd_limit;
    logic        fwd;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    io_window_decoder dut (
        .clk(clk), .rst_n(rst_n), .cfg_wr_en(cfg_wr_en), .cfg_wr_sel(cfg_wr_sel),
        .cfg_wr_data(cfg_wr_data), .fine_gran_en(fine_gran_en), .wr_lock(wr_lock),
        .io_space_en(io_space_en), .addr_valid(addr_valid), .addr(addr),
        .cfg_rd_base(cfg_rd_base), .cfg_rd_limit(cfg_rd_limit), .fwd(fwd)
    );

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    function automatic logic model_hit(input logic [7:0] b, input logic [7:0] l,
                                       input logic fine, input logic [15:0] a);
        logic [5:0] lo, hi;
        lo = fine ? b[7:2] : {b[7:4], 2'b00};
        hi = fine ? l[7:2] : {l[7:4], 2'b11};
        return (a[15:10] >= lo) && (a[15:10] <= hi);
    endfunction

    task automatic wr(input logic sel, input logic [7:0] data);
        @(negedge clk);
        cfg_wr_en = 1'b1; cfg_wr_sel = sel; cfg_wr_data = data;
        @(negedge clk);
        cfg_wr_en = 1'b0;
    endtask

    task automatic probe(input string req, input logic [15:0] a, input logic exp);
        @(negedge clk);
        addr_valid = 1'b1; addr = a;
        @(negedge clk);
        addr_valid = 1'b0;
        check(req, {15'd0, fwd}, {15'd0, exp});
    endtask

    task automatic t_reset;
        check("R1 base", {8'd0, cfg_rd_base}, 16'h00F0);
        check("R1 limit", {8'd0, cfg_rd_limit}, 16'h0000);
        check("R1 fwd", {15'd0, fwd}, 16'h0);
        probe("R1 empty 0xF000", 16'hF000, 1'b0);
        probe("R1 empty 0x0000", 16'h0000, 1'b0);
    endtask

    task automatic t_coarse;
        fine_gran_en = 1'b0; wr_lock = 1'b0;
        wr(1'b0, 8'h2F);
        wr(1'b1, 8'h4F);
        check("R2 base hi", {8'd0, cfg_rd_base}, 16'h0020);
        check("R3 R4 limit low bits", {8'd0, cfg_rd_limit}, 16'h0040);
        probe("R7 below", 16'h1FFF, model_hit(8'h20, 8'h40, 1'b0, 16'h1FFF));
        probe("R7 bottom", 16'h2000, model_hit(8'h20, 8'h40, 1'b0, 16'h2000));
        probe("R7 top", 16'h4FFF, model_hit(8'h20, 8'h40, 1'b0, 16'h4FFF));
        probe("R7 above", 16'h5000, model_hit(8'h20, 8'h40, 1'b0, 16'h5000));
    endtask

    task automatic t_coarse_write_ignored;
        fine_gran_en = 1'b1;
        @(negedge clk);
        check("R4 fine bits kept base", {8'd0, cfg_rd_base}, 16'h0020);
        check("R4 fine bits kept limit", {8'd0, cfg_rd_limit}, 16'h0040);
    endtask

    task automatic t_fine;
        fine_gran_en = 1'b1; wr_lock = 1'b0;
        wr(1'b0, 8'h24);
        wr(1'b1, 8'h4B);
        check("R5 base", {8'd0, cfg_rd_base}, 16'h0024);
        check("R5 R3 limit", {8'd0, cfg_rd_limit}, 16'h0048);
        probe("R8 below", 16'h23FF, model_hit(8'h24, 8'h48, 1'b1, 16'h23FF));
        probe("R8 bottom", 16'h2400, model_hit(8'h24, 8'h48, 1'b1, 16'h2400));
        probe("R8 top", 16'h4BFF, model_hit(8'h24, 8'h48, 1'b1, 16'h4BFF));
        probe("R8 above", 16'h4C00, model_hit(8'h24, 8'h48, 1'b1, 16'h4C00));
    endtask

    task automatic t_lock;
        wr_lock = 1'b1;
        wr(1'b0, 8'h3C);
        wr(1'b1, 8'h54);
        check("R6 base hi written fine kept", {8'd0, cfg_rd_base}, 16'h0034);
        check("R6 limit hi written fine kept", {8'd0, cfg_rd_limit}, 16'h0058);
        wr_lock = 1'b0;
        wr(1'b0, 8'h24);
        wr(1'b1, 8'h48);
    endtask

    task automatic t_gating;
        io_space_en = 1'b0;
        probe("R11 space off", 16'h3000, 1'b0);
        io_space_en = 1'b1;
        @(negedge clk);
        addr_valid = 1'b0; addr = 16'h3000;
        @(negedge clk);
        check("R10 no valid", {15'd0, fwd}, 16'h0);
        @(negedge clk);
        addr_valid = 1'b1;
        @(posedge clk);
        #1;
        check("R10 registered", {15'd0, fwd}, 16'h1);
        @(negedge clk);
        addr_valid = 1'b0;
        @(negedge clk);
        check("R10 drops", {15'd0, fwd}, 16'h0);
    endtask

    task automatic t_inverted;
        fine_gran_en = 1'b0;
        wr(1'b0, 8'h80);
        wr(1'b1, 8'h30);
        probe("R9 at limit", 16'h3000, 1'b0);
        probe("R9 between", 16'h5000, 1'b0);
        probe("R9 at base", 16'h8000, 1'b0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        io_space_en = 1'b1;
        @(negedge clk);
        t_reset();
        t_coarse();
        t_coarse_write_ignored();
        t_fine();
        t_lock();
        t_gating();
        t_inverted();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule